// File: doc/BRIEF.md
# Conflict-Free Cell Bank Allocator

This block picks a storage bank for every fixed-size cell that enters a shared-memory switch. The switch stores cells in a set of single-ported banks, and each bank can do one write or one read per time slot. Each clock cycle is one time slot. In each slot up to `PORTS` cells may arrive. Each arriving cell carries a delay, which is the number of slots from now until it must leave. The block returns a bank index for each arrival in the same cycle. It also presents the set of banks that must be read in the current slot, so that the cells due now can depart.

A bank is given to a cell only if it is outside three sets: the banks already written by earlier arrivals in this slot, the banks being read in this slot, and the banks holding other cells due in the same future slot. The block records future reads in a circular table with `HORIZON` entries, indexed by departure slot. Each entry is a mask of banks. The entry for the current slot is cleared once it has been presented. With the default `BANKS = 3*PORTS-1` a free bank always exists. An arrival with a bad delay, or an arrival that finds no free bank, raises an error flag and is dropped.

Top module: `cell_bank_alloc`

## Requirements
- R1: While `rst_n` is low and after its release, all table entries are empty. `dep_read` is 0, and `alloc_err` is 0 when no arrival is valid.
- R2: Two arrivals granted in the same slot never receive the same bank.
- R3: A granted arrival never receives a bank that is set in `dep_read` during the same slot.
- R4: A granted arrival never receives a bank that already holds a cell due in the same future slot.
- R5: Arrivals are served in port order, from port 0 upward. Each takes the lowest-numbered bank that is not excluded.
- R6: A valid arrival with delay 0, or with delay of `HORIZON` or more, is not granted, raises `alloc_err` in that cycle, and writes nothing into the table.
- R7: A cell granted bank b with delay d in slot s causes bit b of `dep_read` to be set in slot s+d, counted modulo `HORIZON`. After that slot the entry is empty until it is written again.
- R8: A valid arrival that finds every bank excluded is not granted and raises `alloc_err` in that cycle.
- R9: Field i of `arr_delay` is bits [i*DW +: DW], field i of `arr_bank` is bits [i*BW +: BW], and bit i of `arr_valid`/`arr_grant` belongs to port i. `arr_bank` is the binary bank number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; one cycle is one time slot |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_valid | input | PORTS | Arrival present, per port |
| arr_delay | input | PORTS*DW | Slots until departure, per port |
| arr_grant | output | PORTS | Arrival was given a bank this slot |
| arr_bank | output | PORTS*BW | Chosen bank index, per port |
| dep_read | output | BANKS | Banks read for departures in this slot |
| alloc_err | output | 1 | Bad delay or no free bank in this slot |

## Verification
`arr_grant`, `arr_bank` and `alloc_err` are combinational, so they are due in the same cycle as the arrival. `dep_read` for a grant with delay d is due d clock edges later. The bench drives each slot's inputs just after a rising edge and samples every output two time units later. Each vector therefore compares the grants of its own slot and the reads that earlier vectors put into the table. A table wrap and the clearing of an entry after it has been read are placed at known slot numbers in the vector list.

// File: rtl/cell_bank_alloc.sv
module cell_bank_alloc #(
  parameter int PORTS   = 3,
  parameter int BANKS   = 3*PORTS-1,
  parameter int HORIZON = 16,
  parameter int DW      = 5,
  localparam int BW     = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int SW     = (HORIZON > 1) ? $clog2(HORIZON) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PORTS-1:0]    arr_valid,
  input  logic [PORTS*DW-1:0] arr_delay,
  output logic [PORTS-1:0]    arr_grant,
  output logic [PORTS*BW-1:0] arr_bank,
  output logic [BANKS-1:0]    dep_read,
  output logic                alloc_err
);
  localparam int XW = ((DW > SW) ? DW : SW) + 1;

  logic [BANKS-1:0] table_q [HORIZON];
  logic [BANKS-1:0] add_mask [HORIZON];
  logic [SW-1:0]    cur_q;

  logic [SW-1:0]    dep_slot [PORTS];
  logic [BANKS-1:0] pick_oh  [PORTS];
  logic [BANKS-1:0] busy     [PORTS];
  logic [PORTS-1:0] in_rng;
  logic [BANKS-1:0] wr_used;

  assign dep_read = table_q[cur_q];

  always_comb begin
    logic [XW-1:0]    sum;
    logic [BW-1:0]    pick;
    logic             found;
    logic [BANKS-1:0] used;
    used      = '0;
    alloc_err = 1'b0;
    arr_grant = '0;
    arr_bank  = '0;
    for (int i = 0; i < PORTS; i++) begin
      in_rng[i] = (arr_delay[i*DW +: DW] != '0) &&
                  (XW'(arr_delay[i*DW +: DW]) < XW'(HORIZON));
      sum = XW'(cur_q) + XW'(arr_delay[i*DW +: DW]);
      if (sum >= XW'(HORIZON)) sum = sum - XW'(HORIZON);
      dep_slot[i] = in_rng[i] ? sum[SW-1:0] : '0;
      busy[i] = used | dep_read | (in_rng[i] ? table_q[dep_slot[i]] : '0);
      pick  = '0;
      found = 1'b0;
      for (int b = BANKS-1; b >= 0; b--) begin
        if (!busy[i][b]) begin
          pick  = BW'(b);
          found = 1'b1;
        end
      end
      pick_oh[i] = '0;
      if (arr_valid[i] && in_rng[i] && found) begin
        arr_grant[i] = 1'b1;
        arr_bank[i*BW +: BW] = pick;
        pick_oh[i][pick] = 1'b1;
        used = used | pick_oh[i];
      end
      if (arr_valid[i] && !(in_rng[i] && found)) alloc_err = 1'b1;
    end
    wr_used = used;
  end

  always_comb begin
    for (int h = 0; h < HORIZON; h++) begin
      add_mask[h] = '0;
      for (int i = 0; i < PORTS; i++)
        if (arr_grant[i] && dep_slot[i] == SW'(h)) add_mask[h] = add_mask[h] | pick_oh[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      for (int h = 0; h < HORIZON; h++) table_q[h] <= '0;
    end else begin
      cur_q <= (cur_q == SW'(HORIZON-1)) ? '0 : cur_q + 1'b1;
      for (int h = 0; h < HORIZON; h++)
        table_q[h] <= (SW'(h) == cur_q) ? '0 : (table_q[h] | add_mask[h]);
    end
  end

  p_distinct_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_used) == $countones(arr_grant));

  p_no_read_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_used & dep_read) == '0);

  for (genvar g = 0; g < PORTS; g++) begin : g_chk
    p_no_future_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
      arr_grant[g] |-> (table_q[dep_slot[g]] & pick_oh[g]) == '0);

    p_bad_delay_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_valid[g] && !in_rng[g]) |-> (alloc_err && !arr_grant[g]));

    p_grant_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      arr_grant[g] |-> arr_valid[g]);
  end
endmodule

// File: tb/cell_bank_alloc_tb.sv
module cell_bank_alloc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;
  localparam int VW = 39;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] arr_valid = '0;
  logic [14:0] arr_delay = '0;
  logic [2:0] arr_grant;
  logic [8:0] arr_bank;
  logic [7:0] dep_read;
  logic       alloc_err;

  logic [2:0] s_valid = '0;
  logic [14:0] s_delay = '0;
  logic [2:0] s_grant;
  logic [5:0] s_bank;
  logic [3:0] s_read;
  logic       s_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_bank_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_delay(arr_delay),
    .arr_grant(arr_grant), .arr_bank(arr_bank), .dep_read(dep_read), .alloc_err(alloc_err));

  cell_bank_alloc #(.BANKS(4)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .arr_valid(s_valid), .arr_delay(s_delay),
    .arr_grant(s_grant), .arr_bank(s_bank), .dep_read(s_read), .alloc_err(s_err));

  // {valid, d0, d1, d2, grant, bank0, bank1, bank2, read mask, err}; slot k = row k
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'b111, 5'd1,  5'd1,  5'd2,  3'b111, 3'd0, 3'd1, 3'd2, 8'h00, 1'b0}, // R2 R5
    {3'b111, 5'd1,  5'd1,  5'd1,  3'b111, 3'd3, 3'd4, 3'd5, 8'h03, 1'b0}, // R3 R4
    {3'b101, 5'd3,  5'd0,  5'd14, 3'b101, 3'd0, 3'd0, 3'd1, 8'h3C, 1'b0}, // R3 wrap
    {3'b111, 5'd2,  5'd2,  5'd0,  3'b011, 3'd1, 3'd2, 3'd0, 8'h00, 1'b1}, // R4 R6
    {3'b010, 5'd0,  5'd16, 5'd0,  3'b000, 3'd0, 3'd0, 3'd0, 8'h00, 1'b1}, // R6
    {3'b111, 5'd11, 5'd11, 5'd11, 3'b111, 3'd3, 3'd4, 3'd5, 8'h07, 1'b0}, // R4 R7
    {3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 3'd0, 3'd0, 3'd0, 8'h00, 1'b0},
    {3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 3'd0, 3'd0, 3'd0, 8'h00, 1'b0},
    {3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 3'd0, 3'd0, 3'd0, 8'h00, 1'b0},
    {3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 3'd0, 3'd0, 3'd0, 8'h00, 1'b0},
    {3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 3'd0, 3'd0, 3'd0, 8'h00, 1'b0},
    {3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 3'd0, 3'd0, 3'd0, 8'h00, 1'b0},
    {3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 3'd0, 3'd0, 3'd0, 8'h00, 1'b0},
    {3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 3'd0, 3'd0, 3'd0, 8'h00, 1'b0},
    {3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 3'd0, 3'd0, 3'd0, 8'h00, 1'b0},
    {3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 3'd0, 3'd0, 3'd0, 8'h00, 1'b0},
    {3'b001, 5'd1,  5'd0,  5'd0,  3'b001, 3'd0, 3'd0, 3'd0, 8'h3A, 1'b0}, // R7 wrap read
    {3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 3'd0, 3'd0, 3'd0, 8'h01, 1'b0},    // R7 cleared
    {3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 3'd0, 3'd0, 3'd0, 8'h00, 1'b0}     // R7 cleared
  };

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset dep_read", int'(dep_read), 0);
    chk("R1 reset alloc_err", int'(alloc_err), 0);
    chk("R1 reset grant", int'(arr_grant), 0);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      arr_valid = v[38:36];
      arr_delay = {v[25:21], v[30:26], v[35:31]};
      #2;
      chk($sformatf("R6 R8 grant slot %0d", k), int'(arr_grant), int'(v[20:18]));
      for (int p = 0; p < 3; p++)
        if (v[18+p]) chk($sformatf("R5 R9 bank port %0d slot %0d", p, k),
                         int'(arr_bank[p*3 +: 3]), int'(v[17-3*p -: 3]));
      chk($sformatf("R7 dep_read slot %0d", k), int'(dep_read), int'(v[8:1]));
      chk($sformatf("R6 alloc_err slot %0d", k), int'(alloc_err), int'(v[0]));
      @(posedge clk);
      #1;
    end
    arr_valid = '0;
    // R8: four banks, three arrivals, then a slot with three banks read out
    s_valid = 3'b111;
    s_delay = {5'd1, 5'd1, 5'd1};
    #2;
    chk("R2 small grant", int'(s_grant), 7);
    chk("R5 small banks", int'(s_bank), int'({2'd2, 2'd1, 2'd0}));
    @(posedge clk);
    #1;
    s_valid = 3'b011;
    #2;
    chk("R3 small dep_read", int'(s_read), 7);
    chk("R8 small grant", int'(s_grant), 1);
    chk("R8 small bank port0", int'(s_bank[1:0]), 3);
    chk("R8 small alloc_err", int'(s_err), 1);
    @(posedge clk);
    #1;
    s_valid = '0;
    // R1: reset empties the table; the bank 3 read due now must vanish
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    #2;
    chk("R1 small dep_read after reset", int'(s_read), 0);
    chk("R1 small alloc_err after reset", int'(s_err), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule